// File: doc/BRIEF.md
# Conversion Start and Data-Ready Sequencer

This block decides when the digital back end of a delta-sigma converter runs conversions, and when the active-low data-ready strobe is shown to the host. A conversion run is requested by a level on the start pin or by a one-cycle start command pulse. The command pulse sets an internal run latch, and a stop pulse clears it. When a run begins, the block captures the data-rate code, the clock-divide bit and the mode bit. It then holds data-ready high while it counts out the settling delay in modulator periods. One modulator period is 4 or 16 input clocks, depending on the divide bit.

When the delay has elapsed, including one period of margin, data-ready falls for a fixed number of clocks and a result-valid strobe fires. In continuous mode, every later output-period tick from the filter produces another pulse. In single-shot mode, exactly one result is produced, and the block then waits for a fresh start. A step-event input marks the next three results as unsettled, so that a consumer can discard them. The reserved rate code raises an error flag instead of starting.

Top module: `cnv_start_seq`

## Requirements
- R1: After a synchronous reset, `drdy_n` is 1, and `res_valid` and `rate_err` are 0.
- R2: The run condition is `start_pin` OR an internal latch. A `start_cmd` pulse sets the latch and a `stop_cmd` pulse clears it. With the pin low, a command-started run keeps producing results until a stop pulse arrives.
- R3: When a run starts, `drdy_n` is held high. With `cfg_div_hi`=0, the first fall comes exactly (2^(12-code)+4+1)*4 clocks after the edge that samples the start, for `cfg_rate` codes 0 to 6.
- R4: With `cfg_div_hi`=1, the modulator period is 16 clocks, so the first-fall delay is (2^(12-code)+4+1)*16 clocks.
- R5: In continuous mode (`cfg_single`=0), after the first result, an `out_tick` sampled while `drdy_n` is high makes `drdy_n` fall on that same edge. A tick sampled while `drdy_n` is low is ignored.
- R6: Each fall of `drdy_n` lasts PULSE_CLKS clocks (default 4). `res_valid` is high for exactly the first clock of each low pulse.
- R7: In single-shot mode (`cfg_single`=1), a run yields one fall and then ignores `out_tick`. A new result needs the pin to return low and go high again, or a new `start_cmd`.
- R8: Rate code 3'b111 is reserved. A start request made with it sets `rate_err` on the next clock, and `drdy_n` stays high.
- R9: If the run condition drops while settling or running, `drdy_n` is high on the next clock and no further fall occurs.
- R10: The first result of a run has `res_settled`=1. After a `step_evt` pulse, the next three results have `res_settled`=0 and the fourth has `res_settled`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pin | input | 1 | Start level from the pin |
| start_cmd | input | 1 | One-cycle decoded start command |
| stop_cmd | input | 1 | One-cycle decoded stop command |
| cfg_single | input | 1 | Mode bit: 1 single-shot, 0 continuous |
| cfg_rate | input | 3 | Data-rate code, 7 reserved |
| cfg_div_hi | input | 1 | Modulator period: 0 gives 4 clocks, 1 gives 16 clocks |
| out_tick | input | 1 | One pulse per filter output period |
| step_evt | input | 1 | Input step seen; the next three results are unsettled |
| drdy_n | output | 1 | Active-low data-ready |
| res_valid | output | 1 | One-cycle strobe on each data-ready fall |
| res_settled | output | 1 | Qualifies `res_valid`: the result is fully settled |
| rate_err | output | 1 | Start was requested with the reserved rate code |

## Verification
A wrong prescaler reload or a wrong period target shows up as a first fall that is early or late by whole modulator periods. The scoreboard catches this at the first result of the affected rate and divide pair, because it compares the exact edge of each fall. A run latch that is stuck set or stuck clear shows up within one output tick after a stop or a command start. A corrupted pulse counter shows up at the next rising edge of `drdy_n`. A broken step counter mislabels `res_settled` within four results.

// File: rtl/cnv_seq_pkg.sv
// Shared types and the settling-length computation for the sequencer.
// Assumes rate codes 0..6 are valid and 7 is reserved.
package cnv_seq_pkg;
    localparam int RATE_W = 3;
    localparam int PER_W  = 14;
    localparam logic [RATE_W-1:0] RATE_RSVD = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_RUN,
        ST_DONE
    } seq_state_t;

    // Settling length in modulator periods: a power of two plus four, plus margin.
    function automatic logic [PER_W-1:0] settle_periods(input logic [RATE_W-1:0] code,
                                                        input int margin);
        int sh;
        sh = 12 - int'(code);
        return PER_W'((1 << sh) + 4 + margin);
    endfunction
endpackage

// File: rtl/cnv_run_ctl.sv
// Run-condition logic: combines the start pin with a latch set by the start
// command and cleared by the stop command or by single-shot completion.
// Assumes the command inputs are one-cycle pulses synchronous to clk.
module cnv_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pin,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic clr_latch,
    output logic run_now
);
    logic latch_q;

    // Latch update: a stop has priority, then a start, then completion clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_cmd) begin
            latch_q <= 1'b0;
        end else if (start_cmd) begin
            latch_q <= 1'b1;
        end else if (clr_latch) begin
            latch_q <= 1'b0;
        end
    end

    assign run_now = start_pin | (~stop_cmd & (start_cmd | latch_q));
endmodule

// File: rtl/cnv_settle_timer.sv
// Counts input clocks into modulator periods and modulator periods up to a
// target. Raises done for the one clock on which the last period completes.
// Assumes DIV_HI >= DIV_LO >= 2 and a nonzero target.
module cnv_settle_timer #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16,
    parameter int PER_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             div_hi,
    input  logic [PER_W-1:0] target,
    output logic             done
);
    localparam int PRE_W = $clog2(DIV_HI);

    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic [PRE_W-1:0] pre_last;
    logic             mod_tick;

    assign pre_last = div_hi ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
    assign mod_tick = run && (pre_q == pre_last);
    assign done     = mod_tick && (per_q == target - PER_W'(1));

    // Prescaler and period counter, both cleared on load.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (run) begin
            if (mod_tick) begin
                pre_q <= '0;
                per_q <= per_q + PER_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/cnv_drdy_gen.sv
// Shapes the active-low data-ready pulse and its valid/settled strobes.
// Tracks how many results remain unsettled after an input step.
// Assumes fire and halt are never high together.
module cnv_drdy_gen #(
    parameter int PULSE_CLKS   = 4,
    parameter int STEP_RESULTS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic halt,
    input  logic clear,
    input  logic step,
    output logic drdy_n,
    output logic res_valid,
    output logic res_settled
);
    localparam int CNT_W = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
    localparam int SC_W  = $clog2(STEP_RESULTS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SC_W-1:0]  sc_q;

    // Pulse shaping: fall on fire, rise after PULSE_CLKS clocks or on halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_n    <= 1'b1;
            cnt_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= fire;
            if (halt) begin
                drdy_n <= 1'b1;
                cnt_q  <= '0;
            end else if (fire) begin
                drdy_n <= 1'b0;
                cnt_q  <= CNT_W'(PULSE_CLKS - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                drdy_n <= 1'b1;
            end
        end
    end

    // Count of unsettled results still due after a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sc_q <= '0;
        end else if (step) begin
            sc_q <= SC_W'(STEP_RESULTS);
        end else if (fire && sc_q != '0) begin
            sc_q <= sc_q - SC_W'(1);
        end
    end

    // Settled qualifier registered alongside res_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_settled <= 1'b0;
        end else begin
            res_settled <= fire && !step && (sc_q == '0);
        end
    end
endmodule

// File: rtl/cnv_start_seq.sv
// Top of the sequencer. Detects start events, captures the configuration,
// times the first settled result, then issues data-ready pulses in
// continuous or single-shot mode. Assumes the config inputs are static
// around a start event; they are captured only then.
module cnv_start_seq
    import cnv_seq_pkg::*;
#(
    parameter int MOD_DIV_LO     = 4,
    parameter int MOD_DIV_HI     = 16,
    parameter int MARGIN_PERIODS = 1,
    parameter int PULSE_CLKS     = 4,
    parameter int STEP_RESULTS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              cfg_single,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_div_hi,
    input  logic              out_tick,
    input  logic              step_evt,
    output logic              drdy_n,
    output logic              res_valid,
    output logic              res_settled,
    output logic              rate_err
);
    seq_state_t        st_q;
    logic [RATE_W-1:0] rate_q;
    logic              div_q;
    logic              single_q;
    logic              run_now;
    logic              start_req;
    logic              rsvd;
    logic              launch;
    logic              t_done;
    logic              fire;
    logic              halt;
    logic              clr_latch;
    logic              active;
    logic [PER_W-1:0]  target;

    cnv_run_ctl run_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pin (start_pin),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .clr_latch (clr_latch),
        .run_now   (run_now)
    );

    assign rsvd      = (cfg_rate == RATE_RSVD);
    assign start_req = (st_q == ST_IDLE) ? run_now
                     : (st_q == ST_DONE) ? (start_cmd & run_now) : 1'b0;
    assign launch    = start_req & ~rsvd;
    assign active    = (st_q == ST_SETTLE) || (st_q == ST_RUN);
    assign target    = settle_periods(rate_q, MARGIN_PERIODS);
    assign fire      = run_now && (((st_q == ST_SETTLE) && t_done)
                     || ((st_q == ST_RUN) && out_tick && drdy_n));
    assign halt      = launch | (active & ~run_now);
    assign clr_latch = (st_q == ST_SETTLE) && t_done && single_q;

    cnv_settle_timer #(
        .DIV_LO (MOD_DIV_LO),
        .DIV_HI (MOD_DIV_HI),
        .PER_W  (PER_W)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .run    (st_q == ST_SETTLE),
        .div_hi (div_q),
        .target (target),
        .done   (t_done)
    );

    cnv_drdy_gen #(
        .PULSE_CLKS   (PULSE_CLKS),
        .STEP_RESULTS (STEP_RESULTS)
    ) drdy_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .halt        (halt),
        .clear       (launch),
        .step        (step_evt),
        .drdy_n      (drdy_n),
        .res_valid   (res_valid),
        .res_settled (res_settled)
    );

    // Configuration capture at each start event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            div_q    <= 1'b0;
            single_q <= 1'b0;
        end else if (launch) begin
            rate_q   <= cfg_rate;
            div_q    <= cfg_div_hi;
            single_q <= cfg_single;
        end
    end

    // Sequencer state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:   if (launch) st_q <= ST_SETTLE;
                ST_SETTLE: begin
                    if (!run_now)    st_q <= ST_IDLE;
                    else if (t_done) st_q <= single_q ? ST_DONE : ST_RUN;
                end
                ST_RUN:    if (!run_now) st_q <= ST_IDLE;
                ST_DONE: begin
                    if (launch)       st_q <= ST_SETTLE;
                    else if (!run_now) st_q <= ST_IDLE;
                end
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // Error flag for a start request carrying the reserved rate code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_err <= 1'b0;
        end else begin
            rate_err <= start_req & rsvd;
        end
    end
endmodule

// File: rtl/cnv_start_seq_chk.sv
// Assertion checker for the sequencer, attached by bind. It observes the
// top-level ports only and tracks the low-pulse length with its own counter.
module cnv_start_seq_chk #(
    parameter int PULSE_CLKS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic drdy_n,
    input logic res_valid,
    input logic res_settled,
    input logic rate_err
);
    logic [15:0] lowc;

    // Counts consecutive low cycles of data-ready.
    always_ff @(posedge clk) begin
        if (!rst_n || drdy_n) begin
            lowc <= '0;
        end else if (lowc != 16'hFFFF) begin
            lowc <= lowc + 16'd1;
        end
    end

    a_r6_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> res_valid);

    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !drdy_n |-> (lowc < 16'(PULSE_CLKS)));

    a_r10_settled_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        res_settled |-> res_valid);

    a_r8_err_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> !res_valid);
endmodule

bind cnv_start_seq cnv_start_seq_chk #(.PULSE_CLKS(PULSE_CLKS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .drdy_n      (drdy_n),
    .res_valid   (res_valid),
    .res_settled (res_settled),
    .rate_err    (rate_err)
);

// File: tb/cnv_start_seq_tb_top.sv
module cnv_start_seq_tb_top;
    localparam int PULSE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_pin = 1'b0, start_cmd = 1'b0, stop_cmd = 1'b0;
    logic       cfg_single = 1'b0, cfg_div_hi = 1'b0;
    logic [2:0] cfg_rate = 3'd6;
    logic       out_tick = 1'b0, step_evt = 1'b0;
    logic       drdy_n, res_valid, res_settled, rate_err;

    always #4 clk = ~clk;

    cnv_start_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_pin(start_pin), .start_cmd(start_cmd),
        .stop_cmd(stop_cmd), .cfg_single(cfg_single), .cfg_rate(cfg_rate),
        .cfg_div_hi(cfg_div_hi), .out_tick(out_tick), .step_evt(step_evt),
        .drdy_n(drdy_n), .res_valid(res_valid), .res_settled(res_settled),
        .rate_err(rate_err)
    );

    typedef struct {
        int    at;
        bit    settled;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   prev = 1'b1;
    int   lowcnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int settle_clks(int code, bit div);
        return ((1 << (12 - code)) + 5) * (div ? 16 : 4);
    endfunction

    // Driver side: called right after inputs change at a falling edge.
    task automatic expect_in(int n, bit s, string r);
        q.push_back('{cyc + 1 + n, s, r});
    endtask

    task automatic wait_drain(int lim);
        int k = 0;
        while (q.size() != 0 && k < lim) begin
            @(negedge clk);
            k++;
        end
        if (q.size() != 0) begin
            chk(1'b0, q[0].req, "expected DRDY fall missing, pending", q.size(), 0);
            q.delete();
        end
    endtask

    task automatic tick_once();
        @(negedge clk) out_tick = 1'b1;
        @(negedge clk) out_tick = 1'b0;
    endtask

    // Monitor: scoreboard compare on each fall, width check on each rise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev && !drdy_n) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected DRDY fall at cycle", cyc, -1);
                end else begin
                    e = q.pop_front();
                    chk(cyc == e.at, e.req, "DRDY fall cycle", cyc, e.at);
                    chk(res_valid == 1'b1, "R6", "res_valid at fall", int'(res_valid), 1);
                    chk(res_settled == e.settled, "R10", "res_settled at fall",
                        int'(res_settled), int'(e.settled));
                end
            end
            if (!drdy_n) lowcnt++;
            if (!prev && drdy_n) begin
                chk(lowcnt == PULSE, "R6", "DRDY low width", lowcnt, PULSE);
                lowcnt = 0;
            end
            prev = drdy_n;
        end
    end

    initial begin
        repeat (198000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(drdy_n == 1'b1, "R1", "drdy_n in reset", int'(drdy_n), 1);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
        chk(rate_err == 1'b0, "R1", "rate_err in reset", int'(rate_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 and R4: exact first-fall delay for every valid rate at both divides.
        for (int div = 0; div < 2; div++) begin
            for (int code = 0; code < 7; code++) begin
                @(negedge clk);
                cfg_rate   = 3'(code);
                cfg_div_hi = div[0];
                start_pin  = 1'b1;
                expect_in(settle_clks(code, div[0]), 1'b1, div ? "R4" : "R3");
                wait_drain(settle_clks(code, div[0]) + 20);
                repeat (PULSE + 2) @(negedge clk);
                start_pin = 1'b0;
                repeat (2) @(negedge clk);
            end
        end

        // R5: continuous ticks; a tick during the low pulse is ignored.
        cfg_rate = 3'd6;
        cfg_div_hi = 1'b0;
        @(negedge clk) start_pin = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R5");
        wait_drain(400);
        repeat (10) @(negedge clk);
        @(negedge clk) out_tick = 1'b1;
        expect_in(0, 1'b1, "R5");
        @(negedge clk) out_tick = 1'b0;
        @(negedge clk) out_tick = 1'b1;
        @(negedge clk) out_tick = 1'b0;
        repeat (10) @(negedge clk);
        chk(q.size() == 0 && drdy_n, "R5", "tick during low pulse ignored", q.size(), 0);

        // R10: three unsettled results after a step, then a settled one.
        @(negedge clk) step_evt = 1'b1;
        @(negedge clk) step_evt = 1'b0;
        for (int i = 0; i < 4; i++) begin
            repeat (8) @(negedge clk);
            out_tick = 1'b1;
            expect_in(0, (i == 3), "R10");
            @(negedge clk) out_tick = 1'b0;
        end
        repeat (8) @(negedge clk);

        // R9: dropping the pin while running stops all pulses.
        @(negedge clk) start_pin = 1'b0;
        @(negedge clk);
        chk(drdy_n == 1'b1, "R9", "drdy_n after pin drop", int'(drdy_n), 1);
        tick_once();
        repeat (10) @(negedge clk);
        chk(drdy_n == 1'b1, "R9", "no fall after stop", int'(drdy_n), 1);

        // R9: dropping the pin during settling gives no fall.
        @(negedge clk) start_pin = 1'b1;
        repeat (100) @(negedge clk);
        start_pin = 1'b0;
        repeat (400) @(negedge clk);
        chk(drdy_n == 1'b1 && q.size() == 0, "R9", "aborted settle", int'(drdy_n), 1);

        // R2: command start with the pin low, latch holds the run, stop clears it.
        @(negedge clk) start_cmd = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R2");
        @(negedge clk) start_cmd = 1'b0;
        wait_drain(400);
        repeat (10) @(negedge clk);
        @(negedge clk) out_tick = 1'b1;
        expect_in(0, 1'b1, "R2");
        @(negedge clk) out_tick = 1'b0;
        wait_drain(5);
        repeat (8) @(negedge clk);
        @(negedge clk) stop_cmd = 1'b1;
        @(negedge clk) stop_cmd = 1'b0;
        tick_once();
        repeat (10) @(negedge clk);
        chk(drdy_n == 1'b1 && q.size() == 0, "R2", "stop command halts", int'(drdy_n), 1);

        // R7: single-shot gives one result; re-arm by pin toggle or command.
        cfg_single = 1'b1;
        @(negedge clk) start_pin = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R7");
        wait_drain(400);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            tick_once();
            repeat (5) @(negedge clk);
        end
        chk(drdy_n == 1'b1 && q.size() == 0, "R7", "ticks ignored after one shot",
            int'(drdy_n), 1);
        @(negedge clk) start_pin = 1'b0;
        repeat (3) @(negedge clk);
        start_pin = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R7");
        wait_drain(400);
        repeat (10) @(negedge clk);
        start_pin = 1'b0;
        repeat (5) @(negedge clk);
        @(negedge clk) start_cmd = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R7");
        @(negedge clk) start_cmd = 1'b0;
        wait_drain(400);
        repeat (10) @(negedge clk);
        @(negedge clk) start_cmd = 1'b1;
        expect_in(settle_clks(6, 1'b0), 1'b1, "R7");
        @(negedge clk) start_cmd = 1'b0;
        wait_drain(400);
        repeat (10) @(negedge clk);
        cfg_single = 1'b0;

        // R8: reserved rate code flags an error and never starts.
        @(negedge clk);
        cfg_rate  = 3'b111;
        start_pin = 1'b1;
        @(negedge clk);
        chk(rate_err == 1'b1, "R8", "rate_err on reserved code", int'(rate_err), 1);
        repeat (300) @(negedge clk);
        chk(drdy_n == 1'b1 && q.size() == 0, "R8", "no fall on reserved code",
            int'(drdy_n), 1);
        start_pin = 1'b0;
        cfg_rate  = 3'd6;
        repeat (5) @(negedge clk);

        chk(q.size() == 0, "R3", "scoreboard empty at end", q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule